// File: doc/BRIEF.md
# Serial Slave Word Shifter

This block answers a serial master as a slave on a four-wire link whose clock idles low. The master lowers an active-low select, toggles a serial clock and presents data; the block returns a word it took from a parallel input and collects the word the master sends. All three serial inputs are oversampled with the block's own system clock, which must run at least twice as fast as the serial clock (in practice several times faster, so each serial clock phase spans more than a few system cycles).

The select is inverted into an active-high frame enable. While the frame is inactive, the transmit register follows the parallel input. When the frame opens, the first bit is driven straight away with no serial clock edge needed; each later bit follows a detected falling edge. Incoming bits are captured on detected rising edges. After the last bit's rising edge the received word is presented with a one-cycle done pulse, and the falling edge after it releases the data output. A select that rises mid-word discards the partial word with no done pulse.

Top module: `spi_slave_shift`

## Requirements
- R1: After reset the output enable is 0, done is 0 and the received word is all zeros.
- R2: Once select goes low, the output enable rises and the data output shows bit WORD_W-1 of the loaded word, before any serial clock edge.
- R3: After each detected falling edge of the serial clock the data output moves to the next lower bit, so that before the k-th rising edge (k counted from 0) it shows bit WORD_W-1-k.
- R4: The bit present on the data input at each rising edge is captured, the first captured bit becoming bit WORD_W-1 of the received word; the received word changes only together with a done pulse.
- R5: The output enable stays 1 between the last rising edge and the next falling edge, and is 0 after that falling edge.
- R6: Done is a single system-cycle pulse, given exactly once per complete word.
- R7: If select rises before the last bit is captured, the output enable drops, no done pulse is given, the received word keeps its old value and the next frame starts from its first bit.
- R8: The transmit word is taken from the parallel input only while select is high; changes to that input during a frame have no effect on the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least twice the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| sel_n_i | input | 1 | Active-low slave select from the master |
| mosi_i | input | 1 | Serial data from the master |
| tx_word_i | input | WORD_W | Word to send, sampled while select is high |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Drive enable for the data output; 0 means high impedance |
| rx_word_o | output | WORD_W | Last complete word received |
| done_o | output | 1 | One-cycle pulse when a word is complete |

## Verification
Every input passes two synchronizer stages, may wait one cycle for the half-rate sample enable and then one state register, so each result is due within five system cycles of the stimulus that causes it. The bench holds each serial clock phase for eight system cycles and checks the data output, the enable and the received word only at the end of a phase, never inside the five-cycle window. Done pulses are counted on every falling system clock edge, so a missing or doubled pulse shows in the count checked at the end of each frame.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2,
      ST_HOLD  = 2'd3
   } slv_state_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_slv_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_slv_tick.sv
module spi_slv_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (DIV == 1) begin : g_full_rate
      assign tick_o = 1'b1;
   end else if (DIV == 2) begin : g_half_rate
      logic phase;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase <= 1'b0;
         else        phase <= ~phase;
      end
      assign tick_o = phase;
   end else begin : g_bad_div
      $error("spi_slv_tick: DIV must be 1 or 2");
      assign tick_o = 1'b0;
   end
endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
   import spi_slv_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              sclk_s_i,
   input  logic              frame_i,
   input  logic              mosi_s_i,
   input  logic [WORD_W-1:0] tx_word_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              done_o
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   slv_state_t        state;
   logic              sclk_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] tx_sr;
   logic [WORD_W-1:0] rx_sr;
   logic              sclk_rise;
   logic              sclk_fall;

   assign sclk_rise = sclk_s_i & ~sclk_q;
   assign sclk_fall = ~sclk_s_i & sclk_q;
   assign miso_o    = tx_sr[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sclk_q    <= 1'b0;
         bit_cnt   <= '0;
         tx_sr     <= '0;
         rx_sr     <= '0;
         rx_word_o <= '0;
         miso_oe_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            sclk_q <= sclk_s_i;
            if (!frame_i) begin
               state     <= ST_IDLE;
               tx_sr     <= tx_word_i;
               bit_cnt   <= '0;
               miso_oe_o <= 1'b0;
            end else begin
               unique case (state)
                  ST_IDLE: begin
                     state     <= ST_SHIFT;
                     miso_oe_o <= 1'b1;
                  end
                  ST_SHIFT: begin
                     if (sclk_rise) begin
                        rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s_i};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) begin
                           rx_word_o <= {rx_sr[WORD_W-2:0], mosi_s_i};
                           done_o    <= 1'b1;
                           state     <= ST_TAIL;
                        end
                     end else if (sclk_fall && bit_cnt != '0) begin
                        tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
                     end
                  end
                  ST_TAIL: begin
                     if (sclk_fall) begin
                        miso_oe_o <= 1'b0;
                        state     <= ST_HOLD;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/spi_slave_shift.sv
module spi_slave_shift #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SAMPLE_DIV  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sel_n_i,
   input  logic              mosi_i,
   input  logic [WORD_W-1:0] tx_word_i,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [WORD_W-1:0] rx_word_o,
   output logic              done_o
);
   if (WORD_W < 2) begin : g_bad_width
      $error("spi_slave_shift: WORD_W must be at least 2");
   end

   localparam int IN_W = 3;

   logic [IN_W-1:0] raw_in;
   logic [IN_W-1:0] sync_in;
   logic            tick;

   assign raw_in = {sel_n_i, sclk_i, mosi_i};

   spi_slv_sync #(
      .WIDTH   (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (sync_in)
   );

   spi_slv_tick #(
      .DIV (SAMPLE_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   spi_slv_core #(
      .WORD_W (WORD_W)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .sclk_s_i  (sync_in[1]),
      .frame_i   (~sync_in[2]),
      .mosi_s_i  (sync_in[0]),
      .tx_word_i (tx_word_i),
      .miso_o    (miso_o),
      .miso_oe_o (miso_oe_o),
      .rx_word_o (rx_word_o),
      .done_o    (done_o)
   );
endmodule

// File: rtl/spi_slave_shift_chk.sv
module spi_slave_shift_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n_i,
   input logic              miso_oe_o,
   input logic [WORD_W-1:0] rx_word_o,
   input logic              done_o
);
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5
   done_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> miso_oe_o);

   // R4
   rx_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word_o) |-> done_o);

   // R7
   release_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_i && $past(sel_n_i, 1) && $past(sel_n_i, 2) && $past(sel_n_i, 3)
       && $past(sel_n_i, 4) && $past(sel_n_i, 5)) |-> !miso_oe_o);

   // R7
   no_done_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_i && $past(sel_n_i, 1) && $past(sel_n_i, 2) && $past(sel_n_i, 3)
       && $past(sel_n_i, 4) && $past(sel_n_i, 5)) |-> !done_o);
endmodule

bind spi_slave_shift spi_slave_shift_chk #(
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_n_i   (sel_n_i),
   .miso_oe_o (miso_oe_o),
   .rx_word_o (rx_word_o),
   .done_o    (done_o)
);

// File: tb/spi_slave_shift_tb.sv
module spi_slave_shift_tb;
   localparam int W  = 8;
   localparam int HP = 8;
   localparam int SETTLE = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sclk_i = 1'b0;
   logic         sel_n_i = 1'b1;
   logic         mosi_i = 1'b0;
   logic [W-1:0] tx_word_i = '0;
   logic         miso_o;
   logic         miso_oe_o;
   logic [W-1:0] rx_word_o;
   logic         done_o;

   int n_chk = 0;
   int n_fail = 0;
   int done_cnt = 0;

   always #2 clk = ~clk;

   spi_slave_shift #(.WORD_W(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_i),
      .sel_n_i   (sel_n_i),
      .mosi_i    (mosi_i),
      .tx_word_i (tx_word_i),
      .miso_o    (miso_o),
      .miso_oe_o (miso_oe_o),
      .rx_word_o (rx_word_o),
      .done_o    (done_o)
   );

   always @(negedge clk) if (rst_n && done_o) done_cnt++;

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // full frame; tx_late is applied to the parallel input after select (R8)
   task automatic run_frame(input logic [W-1:0] tx, input logic [W-1:0] mo,
                            input logic [W-1:0] tx_late);
      int d0;
      tx_word_i = tx;
      wait_clk(HP);
      d0 = done_cnt;
      sel_n_i = 1'b0;
      wait_clk(SETTLE);
      check(miso_oe_o == 1'b1, "R2 oe", miso_oe_o, 1);
      check(miso_o == tx[W-1], "R2 first bit", miso_o, tx[W-1]);
      tx_word_i = tx_late;
      for (int i = 0; i < W; i++) begin
         mosi_i = mo[W-1-i];
         wait_clk(HP);
         check(miso_o == tx[W-1-i], "R3/R8 bit", miso_o, tx[W-1-i]);
         sclk_i = 1'b1;
         wait_clk(HP);
         if (i == W-1) begin
            check(miso_oe_o == 1'b1, "R5 oe before fall", miso_oe_o, 1);
            check(rx_word_o == mo, "R4 rx word", rx_word_o, mo);
            check(done_cnt == d0 + 1, "R6 done count", done_cnt - d0, 1);
         end
         sclk_i = 1'b0;
      end
      wait_clk(HP);
      check(miso_oe_o == 1'b0, "R5 oe after fall", miso_oe_o, 0);
      sel_n_i = 1'b1;
      wait_clk(HP);
      check(done_cnt == d0 + 1, "R6 done once", done_cnt - d0, 1);
   endtask

   task automatic run_abort(input int nbits, input logic [W-1:0] tx);
      int d0;
      logic [W-1:0] rx0;
      tx_word_i = tx;
      wait_clk(HP);
      d0  = done_cnt;
      rx0 = rx_word_o;
      sel_n_i = 1'b0;
      wait_clk(SETTLE);
      for (int i = 0; i < nbits; i++) begin
         mosi_i = ~mosi_i;
         wait_clk(HP);
         sclk_i = 1'b1;
         wait_clk(HP);
         sclk_i = 1'b0;
      end
      wait_clk(HP);
      sel_n_i = 1'b1;
      wait_clk(SETTLE);
      check(miso_oe_o == 1'b0, "R7 oe after abort", miso_oe_o, 0);
      check(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
      check(rx_word_o == rx0, "R7 rx kept", rx_word_o, rx0);
   endtask

   task automatic check_reset();
      check(miso_oe_o == 1'b0, "R1 oe", miso_oe_o, 0);
      check(done_o == 1'b0, "R1 done", done_o, 0);
      check(rx_word_o == '0, "R1 rx", rx_word_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      check_reset();
      run_frame(8'hA5, 8'h3C, 8'hA5);
      run_frame(8'h01, 8'hFF, 8'h01);
      run_frame(8'h80, 8'h00, 8'h80);
      // R8: parallel input changes during frame are ignored
      run_frame(8'h5A, 8'hC3, 8'hFF);
      // R7: abort mid-word, then a clean frame starts from bit 0
      run_abort(3, 8'hF0);
      run_frame(8'h96, 8'h69, 8'h00);
      run_abort(W-1, 8'h0F);
      run_frame(8'h7E, 8'h81, 8'h7E);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule